// File: doc/BRIEF.md
# GPIO Bank with Interrupt Sensing

This block is a register-mapped bank of general-purpose pins, with at most thirty-two pins. A 32-bit register port with address, write strobe, write data and read data puts each pin in one of three modes: plain input, plain output, or interrupt input. For each pin the bank drives an output value and an output enable. Pin inputs pass through a two-flop synchronizer before any logic uses them.

A pin in interrupt mode is watched for a level or for an edge, with a polarity chosen per pin. On banks built with the both-edge option, a pin can also latch on either edge. Latched status bits are gated by a mask and combined into one interrupt line. Software finds the lowest pending bit, clears it by writing 1 to it, and repeats until the line drops.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every readable register holds 0, every output enable is 0 and the interrupt line is low.
- R2: The number of pins is PIN_COUNT. A PIN_COUNT of 0, or one above 32, gives 32 pins. Register bits above the pin count read as 0.
- R3: The mode register is at 0x00, where 1 means interrupt input. The direction register is at 0x04, where 1 means output. The output data register is at 0x08. A pin's output enable is 1 only when its direction bit is 1 and its mode bit is 0. The pin output always carries the output data register.
- R4: If the output data is written before the direction bit is set, the preloaded value appears on the pin with its enable in the cycle right after the direction write.
- R5: Reading 0x0C returns the pin inputs as the two-flop synchronizer holds them, which is two clock edges after a pin changes.
- R6: In level mode (bit at 0x24 is 0), the status bit at 0x10 follows the synchronized pin XOR the polarity bit at 0x20 on every clock. A polarity of 1 means active low.
- R7: In edge mode (bit at 0x24 is 1) with both-edge off, a rising edge sets the status bit when polarity is 0 and a falling edge sets it when polarity is 1. The bit then holds until it is cleared.
- R8: With BOTH_EDGE set, a 1 in the register at 0x4C makes an edge-mode pin latch on both rising and falling edges. With BOTH_EDGE clear, that register reads 0 and writes to it are ignored.
- R9: Writing 1 to a bit at 0x14 clears that pin's edge status, and writing 0 changes nothing. If an edge and a clear arrive in the same cycle, the status bit ends up set. A clear has no effect on a level-mode status bit.
- R10: Writing 0x1C ORs the write data into the mask. Writing 0x18 keeps only the mask bits where the data is 1. Reading 0x18 returns the mask. The interrupt line is high exactly when status AND mask is nonzero.
- R11: A pin in general I/O mode (mode bit 0) never sets its status bit.
- R12: Reads of 0x14, 0x1C or any unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, available in the same cycle |
| pin_in | input | pins | Asynchronous pin inputs |
| pin_out | output | pins | Output data for each pin |
| pin_oe | output | pins | Output enable for each pin |
| irq | output | 1 | Combined masked interrupt |

## Verification
A bad status bit in edge mode stays latched, so it shows up in the status read and on irq from the third clock edge after the pin moves, and it remains visible until the bit is cleared. A bad level-mode bit is overwritten on the next clock, so the bench samples it in the window right after the synchronizer settles. A wrong mask bit shows on irq in the first cycle after the mask write. The clear-versus-edge race is aimed at the exact cycle in which the detected edge and the clear strobe meet.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned BUS_W    = 32;
  localparam int unsigned MAX_PINS = 32;

  // Register byte offsets, decoded by the software driver.
  localparam logic [7:0] OFS_MODE = 8'h00;
  localparam logic [7:0] OFS_DIR  = 8'h04;
  localparam logic [7:0] OFS_OUT  = 8'h08;
  localparam logic [7:0] OFS_IN   = 8'h0C;
  localparam logic [7:0] OFS_STAT = 8'h10;
  localparam logic [7:0] OFS_CLR  = 8'h14;
  localparam logic [7:0] OFS_MASK = 8'h18;
  localparam logic [7:0] OFS_MSET = 8'h1C;
  localparam logic [7:0] OFS_POL  = 8'h20;
  localparam logic [7:0] OFS_EDGE = 8'h24;
  localparam logic [7:0] OFS_BOTH = 8'h4C;

  // Pin count actually built: out-of-range requests fall back to the maximum.
  function automatic int unsigned eff_pins(input int unsigned req);
    return (req == 0 || req > MAX_PINS) ? MAX_PINS : req;
  endfunction

  // Edge detector on one synchronized pin.
  function automatic logic edge_hit(input logic cur, input logic prev,
                                    input logic pol, input logic both);
    if (both) return cur ^ prev;
    return pol ? (prev & ~cur) : (cur & ~prev);
  endfunction

  // Next value of one status bit.
  function automatic logic status_next(input logic mode, input logic edg,
                                       input logic cur, input logic pol,
                                       input logic hit, input logic clr,
                                       input logic old);
    if (!mode) return 1'b0;
    if (!edg)  return cur ^ pol;
    if (hit)   return 1'b1;
    if (clr)   return 1'b0;
    return old;
  endfunction
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      sync_out <= '0;
    end else begin
      stage1_q <= async_in;
      sync_out <= stage1_q;
    end
  end
endmodule

// File: rtl/gpio_bank_sense.sv
module gpio_bank_sense
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sync_in,
  input  logic [N-1:0] mode,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] edge_sel,
  input  logic [N-1:0] both,
  input  logic [N-1:0] clr,
  output logic [N-1:0] status
);
  logic [N-1:0] prev_q;
  logic [N-1:0] hit;      // edge event per pin, brought out for checks

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_in;
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    assign hit[i] = edge_hit(sync_in[i], prev_q[i], pol[i], both[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) status[i] <= 1'b0;
      else status[i] <= status_next(mode[i], edge_sel[i], sync_in[i], pol[i],
                                    hit[i], clr[i], status[i]);
    end
  end

  // R11: general I/O pins never latch status
  p_gen_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (status & ~$past(mode)) == '0);

  // R6: level status tracks polarity-adjusted synchronized input
  p_level_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((status ^ $past(sync_in ^ pol)) & $past(mode & ~edge_sel)) == '0);

  // R7: edge status holds without event or clear
  p_edge_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((status ^ $past(status)) & $past(mode & edge_sel & ~hit & ~clr)) == '0);

  // R9: a detected edge wins over a simultaneous clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (status & $past(mode & edge_sel & hit)) == $past(mode & edge_sel & hit));
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N      = 32,
  parameter bit          BOTH   = 1'b1,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [N-1:0]      sync_in,
  input  logic [N-1:0]      status,
  output logic [N-1:0]      mode_q,
  output logic [N-1:0]      dir_q,
  output logic [N-1:0]      out_q,
  output logic [N-1:0]      pol_q,
  output logic [N-1:0]      edge_q,
  output logic [N-1:0]      both_q,
  output logic [N-1:0]      mask_q,
  output logic [N-1:0]      clr_pulse
);
  logic [N-1:0] wd;
  logic we_mode, we_dir, we_out, we_clr, we_mask, we_mset, we_pol, we_edge, we_both;
  logic [N-1:0] rsel;

  assign wd      = bus_wdata[N-1:0];
  assign we_mode = bus_we && (bus_addr == ADDR_W'(OFS_MODE));
  assign we_dir  = bus_we && (bus_addr == ADDR_W'(OFS_DIR));
  assign we_out  = bus_we && (bus_addr == ADDR_W'(OFS_OUT));
  assign we_clr  = bus_we && (bus_addr == ADDR_W'(OFS_CLR));
  assign we_mask = bus_we && (bus_addr == ADDR_W'(OFS_MASK));
  assign we_mset = bus_we && (bus_addr == ADDR_W'(OFS_MSET));
  assign we_pol  = bus_we && (bus_addr == ADDR_W'(OFS_POL));
  assign we_edge = bus_we && (bus_addr == ADDR_W'(OFS_EDGE));
  assign we_both = bus_we && (bus_addr == ADDR_W'(OFS_BOTH));

  assign clr_pulse = we_clr ? wd : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      dir_q  <= '0;
      out_q  <= '0;
      pol_q  <= '0;
      edge_q <= '0;
      mask_q <= '0;
    end else begin
      if (we_mode) mode_q <= wd;
      if (we_dir)  dir_q  <= wd;
      if (we_out)  out_q  <= wd;
      if (we_pol)  pol_q  <= wd;
      if (we_edge) edge_q <= wd;
      if (we_mask)      mask_q <= mask_q & wd;
      else if (we_mset) mask_q <= mask_q | wd;
    end
  end

  if (BOTH) begin : g_both
    always_ff @(posedge clk) begin
      if (!rst_n)       both_q <= '0;
      else if (we_both) both_q <= wd;
    end
  end else begin : g_no_both
    assign both_q = '0;
  end

  always_comb begin
    rsel = '0;
    case (bus_addr)
      ADDR_W'(OFS_MODE): rsel = mode_q;
      ADDR_W'(OFS_DIR):  rsel = dir_q;
      ADDR_W'(OFS_OUT):  rsel = out_q;
      ADDR_W'(OFS_IN):   rsel = sync_in;
      ADDR_W'(OFS_STAT): rsel = status;
      ADDR_W'(OFS_MASK): rsel = mask_q;
      ADDR_W'(OFS_POL):  rsel = pol_q;
      ADDR_W'(OFS_EDGE): rsel = edge_q;
      ADDR_W'(OFS_BOTH): rsel = both_q;
      default:           rsel = '0;
    endcase
    bus_rdata = '0;
    bus_rdata[N-1:0] = rsel;
  end

  // R10: mask-set write turns on every bit written as 1
  p_mask_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    we_mset && !we_mask |=> (mask_q & $past(wd)) == $past(wd));

  // R10: mask write leaves no bit set where data was 0
  p_mask_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    we_mask |=> (mask_q & ~$past(wd)) == '0);

  // R8: without the option the both-edge register stays empty
  p_no_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !BOTH |-> both_q == '0);
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PIN_COUNT = 32,
  parameter bit          BOTH_EDGE = 1'b1,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic                              bus_we,
  input  logic [31:0]                       bus_wdata,
  output logic [31:0]                       bus_rdata,
  input  logic [eff_pins(PIN_COUNT)-1:0]    pin_in,
  output logic [eff_pins(PIN_COUNT)-1:0]    pin_out,
  output logic [eff_pins(PIN_COUNT)-1:0]    pin_oe,
  output logic                              irq
);
  localparam int unsigned N = eff_pins(PIN_COUNT);

  logic [N-1:0] sync_in, status, mode_q, dir_q, out_q, pol_q, edge_q, both_q, mask_q, clr_pulse;

  gpio_bank_sync #(.W(N)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(sync_in)
  );

  gpio_bank_regs #(.N(N), .BOTH(BOTH_EDGE), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sync_in(sync_in),
    .status(status), .mode_q(mode_q), .dir_q(dir_q), .out_q(out_q),
    .pol_q(pol_q), .edge_q(edge_q), .both_q(both_q), .mask_q(mask_q),
    .clr_pulse(clr_pulse)
  );

  gpio_bank_sense #(.N(N)) u_sense (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .mode(mode_q), .pol(pol_q),
    .edge_sel(edge_q), .both(both_q), .clr(clr_pulse), .status(status)
  );

  assign pin_out = out_q;
  assign pin_oe  = dir_q & ~mode_q;
  assign irq     = |(status & mask_q);

  // R3: a pin in interrupt mode is never driven
  p_irq_pin_undriven_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & mode_q) == '0);
endmodule

// File: tb/gpio_irq_bank_tb.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we_m = 1'b0, we_a = 1'b0;
  logic [31:0] rd_m, rd_a;
  logic [11:0] pin_m = '0, out_m, oe_m;
  logic [31:0] pin_a = '0, out_a, oe_a;
  logic        irq_m, irq_a;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_bank #(.PIN_COUNT(12), .BOTH_EDGE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we_m), .bus_wdata(wdata),
    .bus_rdata(rd_m), .pin_in(pin_m), .pin_out(out_m), .pin_oe(oe_m), .irq(irq_m)
  );

  gpio_irq_bank #(.PIN_COUNT(0), .BOTH_EDGE(1'b0)) u_alt (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we_a), .bus_wdata(wdata),
    .bus_rdata(rd_a), .pin_in(pin_a), .pin_out(out_a), .pin_oe(oe_a), .irq(irq_a)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input bit alt, input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d;
    if (alt) we_a = 1'b1; else we_m = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we_a = 1'b0; we_m = 1'b0;
  endtask

  task automatic rd(input bit alt, input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = alt ? rd_a : rd_m;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    logic [7:0] regs [9] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h18, 8'h20, 8'h24, 8'h4C};
    foreach (regs[i]) begin
      rd(1'b0, regs[i], v);
      check("R1 register zero", v, 32'h0);
    end
    check("R1 oe zero", {20'h0, oe_m}, 32'h0);
    check("R1 irq low", {31'h0, irq_m}, 32'h0);
  endtask

  task automatic t_width;
    logic [31:0] v;
    wr(1'b0, 8'h04, 32'hFFFF_FFFF);
    rd(1'b0, 8'h04, v);
    check("R2 twelve pins", v, 32'h0000_0FFF);
    wr(1'b0, 8'h04, 32'h0);
    wr(1'b1, 8'h04, 32'hFFFF_FFFF);
    rd(1'b1, 8'h04, v);
    check("R2 count 0 gives 32", v, 32'hFFFF_FFFF);
    wr(1'b1, 8'h04, 32'h0);
  endtask

  task automatic t_output;
    wr(1'b0, 8'h08, 32'h5);
    check("R3 no enable before dir", {20'h0, oe_m}, 32'h0);
    check("R3 out data on pin", {20'h0, out_m}, 32'h5);
    wr(1'b0, 8'h04, 32'h1);
    check("R4 preload oe", {20'h0, oe_m}, 32'h1);
    check("R4 preload value", {31'h0, out_m[0]}, 32'h1);
    wr(1'b0, 8'h00, 32'h1);
    check("R3 interrupt mode drops enable", {20'h0, oe_m}, 32'h0);
    wr(1'b0, 8'h00, 32'h0);
    wr(1'b0, 8'h04, 32'h0);
  endtask

  task automatic t_input;
    logic [31:0] v;
    pin_m = 12'hA5C;
    tick(2);
    rd(1'b0, 8'h0C, v);
    check("R5 input read", v, 32'h0000_0A5C);
    pin_m = '0;
    tick(3);
  endtask

  task automatic t_edge;
    logic [31:0] v;
    wr(1'b0, 8'h24, 32'h08);
    wr(1'b0, 8'h00, 32'h08);
    wr(1'b0, 8'h1C, 32'h08);
    pin_m[3] = 1'b1; tick(3);
    rd(1'b0, 8'h10, v);
    check("R7 rising latch", v, 32'h08);
    check("R10 irq on masked status", {31'h0, irq_m}, 32'h1);
    pin_m[3] = 1'b0; tick(3);
    rd(1'b0, 8'h10, v);
    check("R7 status held", v, 32'h08);
    wr(1'b0, 8'h14, 32'h0);
    rd(1'b0, 8'h10, v);
    check("R9 zero write no effect", v, 32'h08);
    wr(1'b0, 8'h14, 32'h08);
    rd(1'b0, 8'h10, v);
    check("R9 clear by one", v, 32'h0);
    check("R9 irq drops", {31'h0, irq_m}, 32'h0);
    // falling-edge pin 4
    wr(1'b0, 8'h20, 32'h10);
    wr(1'b0, 8'h24, 32'h18);
    wr(1'b0, 8'h00, 32'h18);
    pin_m[4] = 1'b1; tick(3);
    rd(1'b0, 8'h10, v);
    check("R7 falling ignores rise", v, 32'h0);
    pin_m[4] = 1'b0; tick(3);
    rd(1'b0, 8'h10, v);
    check("R7 falling latch", v, 32'h10);
    wr(1'b0, 8'h14, 32'h10);
  endtask

  task automatic t_both;
    logic [31:0] v;
    wr(1'b0, 8'h4C, 32'h20);
    wr(1'b0, 8'h24, 32'h38);
    wr(1'b0, 8'h00, 32'h38);
    rd(1'b0, 8'h4C, v);
    check("R8 both reg readback", v, 32'h20);
    pin_m[5] = 1'b1; tick(3);
    rd(1'b0, 8'h10, v);
    check("R8 both rise", v, 32'h20);
    wr(1'b0, 8'h14, 32'h20);
    pin_m[5] = 1'b0; tick(3);
    rd(1'b0, 8'h10, v);
    check("R8 both fall", v, 32'h20);
    wr(1'b0, 8'h14, 32'h20);
    // variant without both-edge
    wr(1'b1, 8'h4C, 32'hFFFF_FFFF);
    rd(1'b1, 8'h4C, v);
    check("R8 absent reads zero", v, 32'h0);
    wr(1'b1, 8'h24, 32'h20);
    wr(1'b1, 8'h00, 32'h20);
    pin_a[5] = 1'b1; tick(3);
    rd(1'b1, 8'h10, v);
    check("R8 absent rise", v, 32'h20);
    wr(1'b1, 8'h14, 32'h20);
    pin_a[5] = 1'b0; tick(3);
    rd(1'b1, 8'h10, v);
    check("R8 absent fall ignored", v, 32'h0);
  endtask

  task automatic t_priority;
    logic [31:0] v;
    pin_m[3] = 1'b1;
    tick(2);
    wr(1'b0, 8'h14, 32'h08);   // clear lands on the edge that sets
    rd(1'b0, 8'h10, v);
    check("R9 set beats clear", v, 32'h08);
    wr(1'b0, 8'h14, 32'h08);
    pin_m[3] = 1'b0; tick(3);
  endtask

  task automatic t_level_mask;
    logic [31:0] v;
    wr(1'b0, 8'h00, 32'h78);
    pin_m[6] = 1'b1; tick(3);
    rd(1'b0, 8'h10, v);
    check("R6 level high", v, 32'h40);
    wr(1'b0, 8'h14, 32'h40);
    tick(1);
    rd(1'b0, 8'h10, v);
    check("R9 clear ignored in level", v, 32'h40);
    pin_m[6] = 1'b0; tick(3);
    rd(1'b0, 8'h10, v);
    check("R6 level follows low", v, 32'h0);
    wr(1'b0, 8'h20, 32'h50);
    tick(1);
    rd(1'b0, 8'h10, v);
    check("R6 active low", v, 32'h40);
    check("R10 unmasked no irq", {31'h0, irq_m}, 32'h0);
    wr(1'b0, 8'h1C, 32'h40);
    check("R10 mask set raises irq", {31'h0, irq_m}, 32'h1);
    rd(1'b0, 8'h18, v);
    check("R10 mask readback", v, 32'h48);
    wr(1'b0, 8'h18, 32'hFFFF_FFBF);
    rd(1'b0, 8'h18, v);
    check("R10 mask clear by zero", v, 32'h08);
    check("R10 irq masked off", {31'h0, irq_m}, 32'h0);
    wr(1'b0, 8'h20, 32'h10);
  endtask

  task automatic t_general;
    logic [31:0] v;
    wr(1'b0, 8'h1C, 32'h80);
    pin_m[7] = 1'b1; tick(3);
    rd(1'b0, 8'h10, v);
    check("R11 general pin no status", v & 32'h80, 32'h0);
    check("R11 no irq", {31'h0, irq_m}, 32'h0);
    pin_m[7] = 1'b0; tick(3);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    rd(1'b0, 8'h14, v); check("R12 clear reg reads 0", v, 32'h0);
    rd(1'b0, 8'h1C, v); check("R12 mask-set reads 0", v, 32'h0);
    rd(1'b0, 8'h30, v); check("R12 unmapped reads 0", v, 32'h0);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_width();
    t_output();
    t_input();
    t_edge();
    t_both();
    t_priority();
    t_level_mask();
    t_general();
    t_unmapped();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule